// File: doc/BRIEF.md
# Thread-Block Dispatcher

This unit takes a grid launch from the host side, given as a block count and a per-block thread count. It hands the blocks out one at a time, in increasing ID order, to an array of multiprocessors. Before a block is handed to a multiprocessor, that target must have room on two counts: resident blocks and resident threads. A block always goes to exactly one multiprocessor, so its threads are never split.

Each multiprocessor has a pair of occupancy counters. An issue raises them, and a completion notice carrying the multiprocessor index and the block's thread count lowers them. Both changes can land in the same clock on the same multiprocessor. Capacity that a retiring block frees can be refilled from the next clock on. When every block has been issued and every issued block has reported back, the unit pulses a grid-done flag and goes idle, ready for a new launch.

A parameter selects how the target is chosen. The default picks the lowest-indexed multiprocessor that fits. The rotating variant starts its search one past the last target.

Top module: `grid_block_dispatcher`

## Requirements
- R1: While idle, a launch with zero blocks, zero threads per block, or more than 768 threads per block raises `launch_err` for exactly the following cycle. `launch_ready` stays high and no block is issued.
- R2: Block IDs appear on `issue_blk_id` as 0, 1, 2, … up to blocks−1. One ID is consumed per cycle in which `issue_valid` and `issue_ready` are both high. While `issue_ready` is low, `issue_valid` stays high and the ID is held.
- R3: No multiprocessor ever holds more than 8 resident blocks. A multiprocessor that already holds 8 is not chosen.
- R4: No multiprocessor ever holds more than 768 resident threads. A block is issued only to a target whose resident threads plus the block's threads do not exceed 768.
- R5: In the default selection mode, `issue_sm` is the lowest index among the multiprocessors that can accept the block.
- R6: A completion notice lowers the named multiprocessor's counts by one block and by `done_threads`. An issue and a completion on the same multiprocessor in one cycle both take effect. The freed room is usable for the issue decision in the next cycle.
- R7: Once all blocks are issued and all have completed, `grid_done` is high for exactly one cycle. It rises one clock after the edge that recorded the last completion, in the same cycle that `launch_ready` returns high.
- R8: While a grid is running, `launch_ready` is low and `launch_valid` has no effect. No `launch_err` is raised and the ID sequence continues.
- R9: `issue_valid` is low while idle, once every block of the grid has been issued, and whenever no multiprocessor passes both limits.
- R10: After reset, `launch_ready` is 1 and `issue_valid`, `grid_done` and `launch_err` are 0. All occupancy counters are empty, so the first block of the next grid goes to multiprocessor 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| launch_valid | input | 1 | Launch request |
| launch_blocks | input | 16 | Grid size in blocks |
| launch_threads | input | 10 | Threads per block |
| launch_ready | output | 1 | High while idle; a launch is taken only then |
| launch_err | output | 1 | One-cycle pulse for a rejected launch |
| issue_valid | output | 1 | A block is offered to a multiprocessor |
| issue_ready | input | 1 | The offered block is taken this cycle |
| issue_blk_id | output | 16 | ID of the offered block |
| issue_sm | output | 4 | Target multiprocessor index |
| done_valid | input | 1 | Completion notice |
| done_sm | input | 4 | Multiprocessor whose block retired |
| done_threads | input | 10 | Thread count of the retired block |
| grid_done | output | 1 | One-cycle pulse when the whole grid has finished |

## Verification
The assertions assume that completion notices are well formed. A notice names only a multiprocessor below the configured count, arrives only while that multiprocessor holds at least one block, and carries the thread count of the grid that is running, so no counter can underflow. The stimulus keeps to these rules by modelling the dispatcher. A queue records every accepted issue, and retirements are produced only from the oldest entries of that queue, carrying the launch's own thread count. The retire policy has a hold depth. It delays notices so the limits are actually reached, including the case where a retirement and an issue hit the same multiprocessor in one cycle.

// File: rtl/gbd_pkg.sv
package gbd_pkg;

   typedef enum logic [0:0] {
      GBD_IDLE = 1'b0,
      GBD_RUN  = 1'b1
   } gbd_state_e;

   localparam int GBD_PICK_LOWEST = 0;
   localparam int GBD_PICK_ROTATE = 1;

endpackage

// File: rtl/gbd_sm_slot.sv
module gbd_sm_slot #(
   parameter int MAX_BLK = 8,
   parameter int MAX_THR = 768,
   parameter int BLK_W   = 4,
   parameter int THR_W   = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  logic             free,
   input  logic [THR_W-1:0] req_thr,
   input  logic [THR_W-1:0] free_thr,
   output logic             fits
);

   logic [BLK_W-1:0] blk_cnt;
   logic [THR_W-1:0] thr_cnt;
   logic [THR_W:0]   thr_sum;

   // Room check on registered counts: a same-cycle free shows up next cycle.
   assign thr_sum = {1'b0, thr_cnt} + {1'b0, req_thr};
   assign fits    = (blk_cnt < BLK_W'(MAX_BLK)) &&
                    (thr_sum <= (THR_W+1)'(MAX_THR));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         blk_cnt <= '0;
         thr_cnt <= '0;
      end else begin
         blk_cnt <= blk_cnt + BLK_W'(take) - BLK_W'(free);
         thr_cnt <= thr_cnt + (take ? req_thr : '0) - (free ? free_thr : '0);
      end
   end

   a_r3_blk_cap : assert property (@(posedge clk) disable iff (!rst_n)
      blk_cnt <= BLK_W'(MAX_BLK));

   a_r4_thr_cap : assert property (@(posedge clk) disable iff (!rst_n)
      thr_cnt <= THR_W'(MAX_THR));

   a_r4_take_has_room : assert property (@(posedge clk) disable iff (!rst_n)
      take |-> fits);

   // Input rule: a retirement names a multiprocessor that holds a block.
   a_r6_free_resident : assert property (@(posedge clk) disable iff (!rst_n)
      free |-> (blk_cnt != '0) && (thr_cnt >= free_thr));

endmodule

// File: rtl/gbd_target_pick.sv
module gbd_target_pick
   import gbd_pkg::*;
#(
   parameter int NUM_SM = 14,
   parameter int SM_W   = 4,
   parameter int MODE   = GBD_PICK_LOWEST
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_SM-1:0] fits,
   input  logic              advance,
   output logic              any_fit,
   output logic [SM_W-1:0]   sel
);

   assign any_fit = |fits;

   generate
      if (MODE == GBD_PICK_ROTATE) begin : g_rotate
         logic [SM_W-1:0] ptr;

         always_comb begin
            int idx;
            sel = '0;
            for (int k = NUM_SM - 1; k >= 0; k--) begin
               idx = int'(ptr) + k;
               if (idx >= NUM_SM) idx = idx - NUM_SM;
               if (fits[idx]) sel = SM_W'(idx);
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       ptr <= '0;
            else if (advance) ptr <= (sel == SM_W'(NUM_SM - 1)) ? '0 : sel + 1'b1;
         end
      end else begin : g_lowest
         always_comb begin
            sel = '0;
            for (int k = NUM_SM - 1; k >= 0; k--) begin
               if (fits[k]) sel = SM_W'(k);
            end
         end
      end
   endgenerate

   a_r5_sel_fits : assert property (@(posedge clk) disable iff (!rst_n)
      any_fit |-> fits[sel]);

   a_r5_advance_legal : assert property (@(posedge clk) disable iff (!rst_n)
      advance |-> any_fit);

endmodule

// File: rtl/gbd_launch_ctrl.sv
module gbd_launch_ctrl
   import gbd_pkg::*;
#(
   parameter int GRID_W  = 16,
   parameter int THR_W   = 10,
   parameter int OUT_W   = 7,
   parameter int MAX_THR = 768
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch_valid,
   input  logic [GRID_W-1:0] launch_blocks,
   input  logic [THR_W-1:0]  launch_threads,
   input  logic              issue_fire,
   input  logic              retire,
   output logic              launch_ready,
   output logic              launch_err,
   output logic              grid_done,
   output logic              running,
   output logic              more,
   output logic [GRID_W-1:0] next_id,
   output logic [THR_W-1:0]  cur_thr
);

   gbd_state_e        state;
   logic [GRID_W-1:0] total;
   logic [OUT_W-1:0]  outstanding;
   logic              bad_launch;

   assign bad_launch   = (launch_blocks == '0) || (launch_threads == '0) ||
                         (launch_threads > THR_W'(MAX_THR));
   assign launch_ready = (state == GBD_IDLE);
   assign running      = (state == GBD_RUN);
   assign more         = (next_id != total);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= GBD_IDLE;
         total       <= '0;
         cur_thr     <= '0;
         next_id     <= '0;
         outstanding <= '0;
         launch_err  <= 1'b0;
         grid_done   <= 1'b0;
      end else begin
         launch_err <= 1'b0;
         grid_done  <= 1'b0;
         unique case (state)
            GBD_IDLE: begin
               if (launch_valid) begin
                  if (bad_launch) begin
                     launch_err <= 1'b1;
                  end else begin
                     state       <= GBD_RUN;
                     total       <= launch_blocks;
                     cur_thr     <= launch_threads;
                     next_id     <= '0;
                     outstanding <= '0;
                  end
               end
            end
            GBD_RUN: begin
               if (issue_fire) next_id <= next_id + 1'b1;
               outstanding <= outstanding + OUT_W'(issue_fire) - OUT_W'(retire);
               if (!more && (outstanding == '0)) begin
                  state     <= GBD_IDLE;
                  grid_done <= 1'b1;
               end
            end
            default: state <= GBD_IDLE;
         endcase
      end
   end

   a_r1_err_needs_idle_request : assert property (@(posedge clk) disable iff (!rst_n)
      launch_err |-> $past(launch_valid) && $past(state == GBD_IDLE));

   a_r1_err_one_cycle : assert property (@(posedge clk) disable iff (!rst_n)
      launch_err |=> !launch_err);

   a_r8_busy_no_err : assert property (@(posedge clk) disable iff (!rst_n)
      (running && launch_valid) |=> !launch_err);

   a_r7_done_once : assert property (@(posedge clk) disable iff (!rst_n)
      grid_done |=> !grid_done);

   a_r6_retire_pending : assert property (@(posedge clk) disable iff (!rst_n)
      retire |-> (outstanding != '0));

   a_r2_id_in_range : assert property (@(posedge clk) disable iff (!rst_n)
      running |-> (next_id <= total));

endmodule

// File: rtl/grid_block_dispatcher.sv
module grid_block_dispatcher
   import gbd_pkg::*;
#(
   parameter int NUM_SM    = 14,
   parameter int MAX_BLK   = 8,
   parameter int MAX_THR   = 768,
   parameter int GRID_W    = 16,
   parameter int PICK_MODE = GBD_PICK_LOWEST,
   localparam int SM_W     = (NUM_SM > 1) ? $clog2(NUM_SM) : 1,
   localparam int THR_W    = $clog2(MAX_THR + 1),
   localparam int BLK_W    = $clog2(MAX_BLK + 1),
   localparam int OUT_W    = $clog2(NUM_SM * MAX_BLK + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch_valid,
   input  logic [GRID_W-1:0] launch_blocks,
   input  logic [THR_W-1:0]  launch_threads,
   output logic              launch_ready,
   output logic              launch_err,
   output logic              issue_valid,
   input  logic              issue_ready,
   output logic [GRID_W-1:0] issue_blk_id,
   output logic [SM_W-1:0]   issue_sm,
   input  logic              done_valid,
   input  logic [SM_W-1:0]   done_sm,
   input  logic [THR_W-1:0]  done_threads,
   output logic              grid_done
);

   // Elaboration-time parameter checks.
   if (NUM_SM < 1) begin : g_bad_num_sm
      $error("grid_block_dispatcher: NUM_SM must be at least 1");
   end
   if (MAX_BLK < 1 || MAX_THR < 1) begin : g_bad_limits
      $error("grid_block_dispatcher: occupancy limits must be positive");
   end
   if (GRID_W < 1) begin : g_bad_grid_w
      $error("grid_block_dispatcher: GRID_W must be positive");
   end
   if (PICK_MODE != GBD_PICK_LOWEST && PICK_MODE != GBD_PICK_ROTATE) begin : g_bad_mode
      $error("grid_block_dispatcher: unknown PICK_MODE");
   end

   logic              running;
   logic              more;
   logic              any_fit;
   logic              issue_fire;
   logic [THR_W-1:0]  cur_thr;
   logic [NUM_SM-1:0] fits;
   logic [NUM_SM-1:0] take;
   logic [NUM_SM-1:0] free;

   gbd_launch_ctrl #(
      .GRID_W  (GRID_W),
      .THR_W   (THR_W),
      .OUT_W   (OUT_W),
      .MAX_THR (MAX_THR)
   ) u_ctrl (
      .clk            (clk),
      .rst_n          (rst_n),
      .launch_valid   (launch_valid),
      .launch_blocks  (launch_blocks),
      .launch_threads (launch_threads),
      .issue_fire     (issue_fire),
      .retire         (done_valid),
      .launch_ready   (launch_ready),
      .launch_err     (launch_err),
      .grid_done      (grid_done),
      .running        (running),
      .more           (more),
      .next_id        (issue_blk_id),
      .cur_thr        (cur_thr)
   );

   gbd_target_pick #(
      .NUM_SM (NUM_SM),
      .SM_W   (SM_W),
      .MODE   (PICK_MODE)
   ) u_pick (
      .clk     (clk),
      .rst_n   (rst_n),
      .fits    (fits),
      .advance (issue_fire),
      .any_fit (any_fit),
      .sel     (issue_sm)
   );

   assign issue_valid = running && more && any_fit;
   assign issue_fire  = issue_valid && issue_ready;

   for (genvar g = 0; g < NUM_SM; g++) begin : g_slot
      assign take[g] = issue_fire && (issue_sm == SM_W'(g));
      assign free[g] = done_valid && (done_sm == SM_W'(g));

      gbd_sm_slot #(
         .MAX_BLK (MAX_BLK),
         .MAX_THR (MAX_THR),
         .BLK_W   (BLK_W),
         .THR_W   (THR_W)
      ) u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .take     (take[g]),
         .free     (free[g]),
         .req_thr  (cur_thr),
         .free_thr (done_threads),
         .fits     (fits[g])
      );
   end

   a_r2_hold_offer : assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && !issue_ready) |=> issue_valid && $stable(issue_blk_id));

   a_r9_idle_quiet : assert property (@(posedge clk) disable iff (!rst_n)
      launch_ready |-> !issue_valid);

   a_r6_done_in_range : assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |-> (int'(done_sm) < NUM_SM));

   a_r3_one_target : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(take));

endmodule

// File: tb/test_grid_block_dispatcher.sv
`timescale 1ns/1ps
module test_grid_block_dispatcher;

   localparam int NSM  = 14;
   localparam int MBLK = 8;
   localparam int MTHR = 768;
   localparam int NV   = 9;
   // blocks, threads, hold depth, backpressure, busy poke, expect error
   localparam int VEC [NV][6] = '{
      '{  1,   1,   1, 0, 0, 0},
      '{ 20, 768,  99, 0, 0, 0},
      '{130,  32, 200, 0, 0, 0},
      '{ 40, 300,   3, 1, 0, 0},
      '{  9,  96,   0, 0, 0, 0},
      '{  6, 256,   2, 0, 1, 0},
      '{  4,   0,   0, 0, 0, 1},
      '{  4, 769,   0, 0, 0, 1},
      '{  0,  64,   0, 0, 0, 1}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        launch_valid = 1'b0;
   logic [15:0] launch_blocks = '0;
   logic [9:0]  launch_threads = '0;
   logic        launch_ready;
   logic        launch_err;
   logic        issue_valid;
   logic        issue_ready = 1'b0;
   logic [15:0] issue_blk_id;
   logic [3:0]  issue_sm;
   logic        done_valid = 1'b0;
   logic [3:0]  done_sm = '0;
   logic [9:0]  done_threads = '0;
   logic        grid_done;

   int checks = 0;
   int errors = 0;
   int mblk [NSM];
   int mthr [NSM];
   int fifo [256];

   always #5 clk = ~clk;

   grid_block_dispatcher i_grid_block_dispatcher (
      .clk, .rst_n, .launch_valid, .launch_blocks, .launch_threads,
      .launch_ready, .launch_err, .issue_valid, .issue_ready, .issue_blk_id,
      .issue_sm, .done_valid, .done_sm, .done_threads, .grid_done
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic check_reset_state();
      chk("R10 launch_ready", int'(launch_ready), 1);
      chk("R10 issue_valid", int'(issue_valid), 0);
      chk("R10 grid_done", int'(grid_done), 0);
      chk("R10 launch_err", int'(launch_err), 0);
   endtask

   task automatic run_vec(input int nb, input int nt, input int hold,
                          input int bp, input int poke, input int experr);
      int issued, head, tail, cyc, exp_sm, rdy, ret, exp_v, rs;
      launch_valid   = 1'b1;
      launch_blocks  = 16'(nb);
      launch_threads = 10'(nt);
      @(posedge clk);
      @(negedge clk);
      launch_valid = 1'b0;
      if (experr != 0) begin
         chk("R1 err pulse", int'(launch_err), 1);
         chk("R1 stays ready", int'(launch_ready), 1);
         chk("R1 no issue", int'(issue_valid), 0);
         @(negedge clk);
         chk("R1 err one cycle", int'(launch_err), 0);
         chk("R1 still no issue", int'(issue_valid), 0);
         return;
      end
      chk("R1 accepted no err", int'(launch_err), 0);
      chk("R8 busy not ready", int'(launch_ready), 0);
      for (int i = 0; i < NSM; i++) begin
         mblk[i] = 0;
         mthr[i] = 0;
      end
      issued = 0; head = 0; tail = 0; cyc = 0;
      while (issued < nb || head != tail) begin
         exp_sm = -1;
         for (int i = NSM - 1; i >= 0; i--)
            if (mblk[i] < MBLK && mthr[i] + nt <= MTHR) exp_sm = i;
         exp_v = (issued < nb && exp_sm >= 0) ? 1 : 0;
         chk("R9 R3 R4 issue_valid", int'(issue_valid), exp_v);
         if (exp_v != 0) begin
            chk("R5 R6 issue_sm", int'(issue_sm), exp_sm);
            chk("R2 issue_blk_id", int'(issue_blk_id), issued);
         end
         rdy = (bp != 0) ? (cyc % 2) : 1;
         issue_ready = rdy[0];
         ret = (head != tail && ((tail - head) >= hold || exp_v == 0 || issued >= nb)) ? 1 : 0;
         rs = fifo[head % 256];
         done_valid   = ret[0];
         done_sm      = 4'(rs);
         done_threads = 10'(nt);
         if (poke != 0) begin
            launch_valid   = 1'b1;
            launch_threads = '0;
            chk("R8 no err while busy", int'(launch_err), 0);
            chk("R8 not ready while busy", int'(launch_ready), 0);
         end
         @(posedge clk);
         if (exp_v != 0 && rdy != 0) begin
            mblk[exp_sm]++;
            mthr[exp_sm] += nt;
            fifo[tail % 256] = exp_sm;
            tail++;
            issued++;
         end
         if (ret != 0) begin
            mblk[rs]--;
            mthr[rs] -= nt;
            head++;
         end
         @(negedge clk);
         cyc++;
      end
      issue_ready  = 1'b0;
      done_valid   = 1'b0;
      launch_valid = 1'b0;
      chk("R7 no early done", int'(grid_done), 0);
      chk("R9 all issued quiet", int'(issue_valid), 0);
      @(negedge clk);
      chk("R7 done pulse", int'(grid_done), 1);
      chk("R7 ready with done", int'(launch_ready), 1);
      @(negedge clk);
      chk("R7 done one cycle", int'(grid_done), 0);
   endtask

   // Watchdog
   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check_reset_state();
      rst_n = 1'b1;
      @(negedge clk);
      check_reset_state();

      for (int v = 0; v < NV; v++)
         run_vec(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], VEC[v][5]);

      // Reset in the middle of a grid, then a fresh grid must start on SM 0.
      launch_valid   = 1'b1;
      launch_blocks  = 16'd5;
      launch_threads = 10'd768;
      @(negedge clk);
      launch_valid = 1'b0;
      issue_ready  = 1'b1;
      repeat (3) @(negedge clk);
      issue_ready = 1'b0;
      rst_n = 1'b0;
      @(negedge clk);
      check_reset_state();
      rst_n = 1'b1;
      @(negedge clk);
      check_reset_state();
      run_vec(3, 512, 1, 0, 0, 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule